// File: doc/BRIEF.md
# Character Cursor Attribute Unit

This unit sits beside the character scan path of a dot-matrix display controller. For every character cell being scanned it decides whether the 5-pixel font row for that cell must be altered to show a cursor. It compares the scanned cell address with the display address counter, either cell by cell or by whole display line. It then produces two masks for the font row: an invert mask for black-white inversion and a force-on mask for the underline and blink patterns. The scan logic forms each output pixel as `(font ^ inv_mask) | force_mask`.

Blinking is timed inside the unit. A frame counter advances on each frame-start pulse, and the blink phase flips once every 32 frames. The counter and the phase return to zero at reset and whenever the display is switched off, so every enable starts with a full visible interval. The masks are combinational in the scan inputs; only the blink timing is registered.

Top module: `cur_attr_unit`

## Requirements
- R1: After reset, with the display on and no frame-start pulse, an inversion or blink cursor on a matching cell gives both masks equal to 0 (blink phase 0).
- R2: With the line-cursor bit clear, a cell is a cursor cell only when `scan_addr` equals `ac_addr`; every other cell gets both masks 0.
- R3: With the line-cursor bit set, every cell whose display line (`addr >> 5`) equals that of `ac_addr` is a cursor cell. Cells on other lines get both masks 0.
- R4: With the underline bit set, a cursor cell on raster row 7 gets `force_mask` = 5'b11111 in either blink phase. Rows 0 to 6 get no underline.
- R5: The blink phase starts at 0, and the 32nd frame-start pulse after reset toggles it. Each later run of 32 pulses toggles it again. Cycles without a pulse leave it unchanged.
- R6: With only the inversion bit set, a cursor cell gets `inv_mask` = 5'b11111 in blink phase 1 and 0 in phase 0. `force_mask` stays 0 on rows 0 to 6.
- R7: With the blink bit set, a cursor cell gets `force_mask` = 5'b11111 in blink phase 1 and 0 in phase 0 (rows 0 to 6).
- R8: When the blink and inversion bits are both set, blink wins and `inv_mask` is 0. The underline adds to either mode: on row 7 `force_mask` is 5'b11111 in both phases.
- R9: While `disp_on` is low, both masks are 0, and the frame counter and blink phase are cleared. After re-enable, 32 pulses are needed again before phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_on | input | 1 | Display enable; low clears blink timing and masks |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| ac_addr | input | 7 | Display address counter (cursor position) |
| scan_addr | input | 7 | Address of the cell being scanned |
| scan_row | input | 3 | Raster row within the cell, 0 at the top |
| cm_invert | input | 1 | Black-white inverting cursor enable |
| cm_underline | input | 1 | Underline cursor enable |
| cm_blink | input | 1 | Blink (all-on alternation) enable |
| cm_line | input | 1 | Apply the cursor to the whole line of the address counter |
| inv_mask | output | 5 | Pixels to invert in the font row |
| force_mask | output | 5 | Pixels to force on in the font row |

## Verification
Two functions can meet on one cell in the same cycle: the underline on the bottom row, and a blink or inversion pattern driven by the blink phase. The bench advances the phase with counted frame pulses. It then scans the cursor cell on row 7 with the underline set together with blink or inversion. It judges that the underline stays forced in both phases while inversion is suppressed under blink. A second overlap occurs when the display switches off in the middle of a blink interval. The bench checks that the masks go to zero and that a full 32 pulses are needed again afterwards.

// File: rtl/cur_attr_pkg.sv
package cur_attr_pkg;

  typedef struct packed {
    logic invert;
    logic underline;
    logic blink;
    logic line;
  } cur_mode_t;

endpackage

// File: rtl/cur_blink_timer.sv
module cur_blink_timer #(
  parameter int BLINK_FRAMES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_on,
  input  logic frame_start,
  output logic [$clog2(BLINK_FRAMES)-1:0] frame_cnt,
  output logic phase
);
  localparam int CNT_W = $clog2(BLINK_FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_FRAMES - 1);

  logic at_last;
  assign at_last = (frame_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (!disp_on) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (frame_start) begin
      if (at_last) begin
        frame_cnt <= '0;
        phase     <= ~phase;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cur_hit_match.sv
module cur_hit_match #(
  parameter int ADDR_W     = 7,
  parameter int LINE_SHIFT = 5
) (
  input  logic [ADDR_W-1:0] ac_addr,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic              line_mode,
  output logic              hit
);
  logic cell_eq;
  logic line_eq;

  assign cell_eq = (ac_addr == scan_addr);

  generate
    if (LINE_SHIFT == 0) begin : g_no_line
      assign line_eq = cell_eq;
    end else begin : g_line
      assign line_eq = (ac_addr[ADDR_W-1:LINE_SHIFT] == scan_addr[ADDR_W-1:LINE_SHIFT]);
    end
  endgenerate

  assign hit = line_mode ? line_eq : cell_eq;
endmodule

// File: rtl/cur_mask_gen.sv
module cur_mask_gen
  import cur_attr_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int PIX_W = 5
) (
  input  logic             disp_on,
  input  logic             hit,
  input  logic             phase,
  input  cur_mode_t        mode,
  input  logic [ROW_W-1:0] scan_row,
  output logic [PIX_W-1:0] inv_mask,
  output logic [PIX_W-1:0] force_mask
);
  localparam logic [ROW_W-1:0] UL_ROW = '1;
  localparam logic [PIX_W-1:0] ALL    = '1;

  logic active;
  logic ul_on;
  logic blink_on;
  logic inv_on;

  always_comb begin
    active   = disp_on && hit;
    ul_on    = active && mode.underline && (scan_row == UL_ROW);
    blink_on = active && mode.blink && phase;
    inv_on   = active && mode.invert && !mode.blink && phase;
    inv_mask   = inv_on ? ALL : '0;
    force_mask = (ul_on || blink_on) ? ALL : '0;
  end
endmodule

// File: rtl/cur_attr_unit.sv
module cur_attr_unit
  import cur_attr_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int LINE_SHIFT   = 5,
  parameter int ROW_W        = 3,
  parameter int PIX_W        = 5,
  parameter int BLINK_FRAMES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_on,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] ac_addr,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic              cm_invert,
  input  logic              cm_underline,
  input  logic              cm_blink,
  input  logic              cm_line,
  output logic [PIX_W-1:0]  inv_mask,
  output logic [PIX_W-1:0]  force_mask
);
  localparam int CNT_W = $clog2(BLINK_FRAMES);

  cur_mode_t        mode;
  logic             hit;
  logic             blink_phase;
  logic [CNT_W-1:0] frame_cnt;

  assign mode = '{invert: cm_invert, underline: cm_underline,
                  blink: cm_blink, line: cm_line};

  cur_blink_timer #(.BLINK_FRAMES(BLINK_FRAMES)) u_timer (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .frame_start(frame_start),
    .frame_cnt(frame_cnt), .phase(blink_phase)
  );

  cur_hit_match #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT)) u_hit (
    .ac_addr(ac_addr), .scan_addr(scan_addr), .line_mode(mode.line), .hit(hit)
  );

  cur_mask_gen #(.ROW_W(ROW_W), .PIX_W(PIX_W)) u_mask (
    .disp_on(disp_on), .hit(hit), .phase(blink_phase), .mode(mode),
    .scan_row(scan_row), .inv_mask(inv_mask), .force_mask(force_mask)
  );
endmodule

// File: rtl/cur_attr_unit_chk.sv
module cur_attr_unit_chk #(
  parameter int ADDR_W       = 7,
  parameter int ROW_W        = 3,
  parameter int PIX_W        = 5,
  parameter int BLINK_FRAMES = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            disp_on,
  input logic                            frame_start,
  input logic [ADDR_W-1:0]               ac_addr,
  input logic [ADDR_W-1:0]               scan_addr,
  input logic [ROW_W-1:0]                scan_row,
  input logic                            cm_invert,
  input logic                            cm_blink,
  input logic                            cm_line,
  input logic [PIX_W-1:0]                inv_mask,
  input logic [PIX_W-1:0]                force_mask,
  input logic [$clog2(BLINK_FRAMES)-1:0] frame_cnt,
  input logic                            blink_phase
);
  localparam int CNT_W = $clog2(BLINK_FRAMES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_FRAMES - 1);

  // R2
  cell_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cm_line && ac_addr != scan_addr) |-> (inv_mask == '0 && force_mask == '0));

  // R4
  ul_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_row != '1 && !cm_blink) |-> force_mask == '0);

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !frame_start) |=> $stable(blink_phase));

  // R5
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && frame_start && frame_cnt == LAST) |=> blink_phase != $past(blink_phase));

  // R6
  inv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_invert |-> inv_mask == '0);

  // R8
  blink_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_blink |-> inv_mask == '0);

  // R9
  off_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (inv_mask == '0 && force_mask == '0));

  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> (frame_cnt == '0 && !blink_phase));
endmodule

bind cur_attr_unit cur_attr_unit_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .PIX_W(PIX_W), .BLINK_FRAMES(BLINK_FRAMES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .frame_start(frame_start),
  .ac_addr(ac_addr), .scan_addr(scan_addr), .scan_row(scan_row),
  .cm_invert(cm_invert), .cm_blink(cm_blink), .cm_line(cm_line),
  .inv_mask(inv_mask), .force_mask(force_mask),
  .frame_cnt(frame_cnt), .blink_phase(blink_phase)
);

// File: tb/cur_attr_unit_test.sv
module cur_attr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_on = 1'b0;
  logic       frame_start = 1'b0;
  logic [6:0] ac_addr = '0;
  logic [6:0] scan_addr = '0;
  logic [2:0] scan_row = '0;
  logic       cm_invert = 1'b0;
  logic       cm_underline = 1'b0;
  logic       cm_blink = 1'b0;
  logic       cm_line = 1'b0;
  logic [4:0] inv_mask;
  logic [4:0] force_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cur_attr_unit uut (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .frame_start(frame_start),
    .ac_addr(ac_addr), .scan_addr(scan_addr), .scan_row(scan_row),
    .cm_invert(cm_invert), .cm_underline(cm_underline), .cm_blink(cm_blink),
    .cm_line(cm_line), .inv_mask(inv_mask), .force_mask(force_mask)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic inv, input logic ul, input logic bl, input logic ln);
    cm_invert = inv; cm_underline = ul; cm_blink = bl; cm_line = ln;
  endtask

  task automatic look(input logic [6:0] sa, input logic [2:0] row);
    scan_addr = sa; scan_row = row;
    #1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; disp_on = 1'b1; frame_start = 1'b0;
    set_mode(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    ac_addr = 7'h05;
    set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    look(7'h05, 3'd0);
    chk("R1 inv after reset", inv_mask, 5'h00);
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    look(7'h05, 3'd0);
    chk("R1 force after reset", force_mask, 5'h00);
  endtask

  task automatic t_cell_and_underline();
    do_reset();
    ac_addr = 7'h22;
    set_mode(1'b0, 1'b1, 1'b0, 1'b0);
    look(7'h22, 3'd7);
    chk("R4 underline row7 phase0", force_mask, 5'h1F);
    look(7'h22, 3'd6);
    chk("R4 no underline row6", force_mask, 5'h00);
    look(7'h23, 3'd7);
    chk("R2 neighbour cell not cursor", force_mask, 5'h00);
    look(7'h2B, 3'd7);
    chk("R2 same line other cell not cursor", force_mask, 5'h00);
  endtask

  task automatic t_line_mode();
    do_reset();
    ac_addr = 7'h23;
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    look(7'h2B, 3'd7);
    chk("R3 same line cell", force_mask, 5'h1F);
    look(7'h20, 3'd7);
    chk("R3 first cell of line", force_mask, 5'h1F);
    look(7'h13, 3'd7);
    chk("R3 other line", force_mask, 5'h00);
    look(7'h43, 3'd7);
    chk("R3 later line", force_mask, 5'h00);
  endtask

  task automatic t_blink_timing();
    do_reset();
    ac_addr = 7'h01;
    set_mode(1'b0, 1'b0, 1'b1, 1'b0);
    pulses(31);
    look(7'h01, 3'd0);
    chk("R5 phase0 after 31 pulses", force_mask, 5'h00);
    repeat (5) @(negedge clk);
    look(7'h01, 3'd0);
    chk("R5 idle cycles hold phase", force_mask, 5'h00);
    pulses(1);
    look(7'h01, 3'd0);
    chk("R7 blink all-on phase1", force_mask, 5'h1F);
    look(7'h02, 3'd0);
    chk("R2 blink off cursor cell", force_mask, 5'h00);
    pulses(32);
    look(7'h01, 3'd0);
    chk("R5 back to phase0 after 64", force_mask, 5'h00);
  endtask

  task automatic t_invert();
    do_reset();
    ac_addr = 7'h10;
    set_mode(1'b1, 1'b0, 1'b0, 1'b0);
    look(7'h10, 3'd2);
    chk("R6 inv phase0", inv_mask, 5'h00);
    pulses(32);
    look(7'h10, 3'd2);
    chk("R6 inv phase1", inv_mask, 5'h1F);
    chk("R6 no force on inversion", force_mask, 5'h00);
  endtask

  task automatic t_priority();
    do_reset();
    ac_addr = 7'h30;
    set_mode(1'b1, 1'b1, 1'b1, 1'b0);
    look(7'h30, 3'd7);
    chk("R8 underline with blink phase0", force_mask, 5'h1F);
    pulses(32);
    look(7'h30, 3'd3);
    chk("R8 blink suppresses inversion", inv_mask, 5'h00);
    chk("R8 blink force phase1", force_mask, 5'h1F);
    set_mode(1'b1, 1'b1, 1'b0, 1'b0);
    look(7'h30, 3'd7);
    chk("R8 underline with inversion inv", inv_mask, 5'h1F);
    chk("R8 underline with inversion force", force_mask, 5'h1F);
  endtask

  task automatic t_disp_off();
    do_reset();
    ac_addr = 7'h08;
    set_mode(1'b1, 1'b1, 1'b0, 1'b0);
    pulses(40);
    look(7'h08, 3'd7);
    chk("R6 phase1 before off", inv_mask, 5'h1F);
    @(negedge clk) disp_on = 1'b0;
    look(7'h08, 3'd7);
    chk("R9 off inv", inv_mask, 5'h00);
    chk("R9 off force", force_mask, 5'h00);
    @(negedge clk) disp_on = 1'b1;
    look(7'h08, 3'd2);
    chk("R9 phase cleared after on", inv_mask, 5'h00);
    pulses(31);
    look(7'h08, 3'd2);
    chk("R9 counter cleared 31 pulses", inv_mask, 5'h00);
    pulses(1);
    look(7'h08, 3'd2);
    chk("R9 phase1 after 32 pulses", inv_mask, 5'h1F);
  endtask

  initial begin
    t_reset_state();
    t_cell_and_underline();
    t_line_mode();
    t_blink_timing();
    t_invert();
    t_priority();
    t_disp_off();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule